// File: doc/BRIEF.md
# Rotating Delay-Line Byte Store

This block is a sequential-access byte store modelled on a recirculating delay line. Every loop holds its bytes as a stream of 4-bit symbols that keeps passing one access point. Each byte takes two back-to-back symbol slots, with the upper nibble first. A shared timer tracks which symbol is at the access point. Every symbol slot lasts `SLOT_CYC` clock cycles. Several loops turn in lockstep. The upper address bits pick the loop and the lower bits pick the byte position in it.

A request is taken on a start strobe. It carries an opcode, an address and a write byte. The controller waits until the addressed byte comes round to the access point. It then reads the two nibbles, replaces them, or leaves them alone, and gives a one-cycle done pulse. The loop contents are held in RAM addressed by the rotating position, which makes a revolution equivalent to a physical loop. Resizing a loop changes only the position counter and the address compare.

Top module: `dlm_top`

## Requirements
- R1: After reset `done` and `dout` are 0, and every stored byte reads back as 0 until it is written. This holds both for reads served in the first revolution after reset and for reads served later.
- R2: Opcode 2'b00 reads, 2'b01 writes, and 2'b10 or 2'b11 is a no-operation.
- R3: A write to address A stores `din` so that a later read of A returns it unchanged. The upper nibble occupies the first slot of the byte and the lower nibble the second.
- R4: Let the tick count be g, counted in clock edges since reset was released. The symbol at the access point is then (g / SLOT_CYC) mod (2·bytes per loop), and a slot ends at an edge where g mod SLOT_CYC = SLOT_CYC-1. A request sampled at edge s is served by the first slot end after s at which the symbol index equals 2·(A mod bytes). `done` is high in the cycle after the slot end SLOT_CYC edges later, so the wait includes wrap-around at capacity.
- R5: `done` is high for exactly one cycle per accepted request.
- R6: Opcode, address and data are latched when the request is accepted. While a request is in progress, further start strobes and changes on `op`, `addr` and `din` have no effect.
- R7: A no-operation waits for the address match like any other request, pulses `done` with the same timing, and leaves the stored bytes unchanged.
- R8: Loops are independent. Two addresses that differ only in the loop-select bits hold separate bytes.
- R9: `dout` changes only when a read completes. It holds its value through writes and no-operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| op | input | 2 | Request opcode |
| addr | input | BYTES_LOG2+LOOPS_LOG2 | Loop select (upper bits) and byte position (lower bits) |
| din | input | 8 | Byte to store on a write |
| dout | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |

## Verification
The case hardest to reach from the ports is a read served during the first revolution after reset. At that point the RAM still holds uninitialised values and a scrub pass is clearing slots only just ahead of the reader. The bench issues a read sweep immediately after reset, so the first several reads fall inside that revolution and the later ones fall after it. The exact latency is predicted from a tick count the bench keeps itself. While each request is in progress the bench scrambles the request inputs and strobes start again, so a request that was not properly latched shows up as wrong data or shifted timing.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_TAIL = 2'd2
  } ctl_state_t;

  localparam logic [1:0] OPC_READ  = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
endpackage

// File: rtl/dlm_timer.sv
module dlm_timer #(
  parameter int BYTES_LOG2 = 8,
  parameter int SLOT_CYC = 4,
  localparam int NIB_W = BYTES_LOG2 + 1,
  localparam int CYC_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic             slot_start,
  output logic             slot_end,
  output logic [NIB_W-1:0] nib_pos,
  output logic             first_rev
);
  logic [CYC_W-1:0] cyc;

  assign slot_end   = (cyc == CYC_W'(SLOT_CYC - 1));
  assign slot_start = (cyc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc       <= '0;
      nib_pos   <= '0;
      first_rev <= 1'b1;
    end else if (slot_end) begin
      cyc     <= '0;
      nib_pos <= nib_pos + 1'b1;
      if (nib_pos == '1) first_rev <= 1'b0;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  // R1
  scrub_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(first_rev) |-> (nib_pos == '0));
endmodule

// File: rtl/dlm_loop.sv
module dlm_loop #(
  parameter int NIB_W = 9,
  localparam int DEPTH = 1 << NIB_W
) (
  input  logic             clk,
  input  logic [NIB_W-1:0] pos,
  input  logic             we,
  input  logic [3:0]       wdata,
  output logic [3:0]       rdata
);
  logic [3:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[pos] <= wdata;
    rdata <= mem[pos];
  end
endmodule

// File: rtl/dlm_ctrl.sv
module dlm_ctrl
  import dlm_pkg::*;
#(
  parameter int BYTES_LOG2 = 8,
  parameter int LOOPS_LOG2 = 1,
  localparam int NIB_W = BYTES_LOG2 + 1,
  localparam int ADDR_W = BYTES_LOG2 + LOOPS_LOG2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            op,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            din,
  input  logic                  slot_end,
  input  logic [NIB_W-1:0]      nib_pos,
  input  logic                  first_rev,
  input  logic [3:0]            rd_nib,
  output logic [LOOPS_LOG2-1:0] loop_sel,
  output logic                  wr_en,
  output logic [3:0]            wr_nib,
  output logic [7:0]            dout,
  output logic                  done
);
  ctl_state_t  state;
  logic [1:0]  op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]  din_q;
  logic [3:0]  hi_q;
  logic        hit;
  logic [3:0]  nib_in;

  assign loop_sel = addr_q[ADDR_W-1:BYTES_LOG2];
  assign hit      = slot_end && (nib_pos == {addr_q[BYTES_LOG2-1:0], 1'b0});
  assign nib_in   = first_rev ? 4'h0 : rd_nib;
  assign wr_en    = (op_q == OPC_WRITE) &&
                    (((state == ST_SEEK) && hit) || ((state == ST_TAIL) && slot_end));
  assign wr_nib   = (state == ST_SEEK) ? din_q[7:4] : din_q[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_q   <= '0;
      addr_q <= '0;
      din_q  <= '0;
      hi_q   <= '0;
      dout   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_q   <= op;
          addr_q <= addr;
          din_q  <= din;
          state  <= ST_SEEK;
        end
        ST_SEEK: if (hit) begin
          hi_q  <= nib_in;
          state <= ST_TAIL;
        end
        ST_TAIL: if (slot_end) begin
          if (op_q == OPC_READ) dout <= {hi_q, nib_in};
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4
  done_align_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(slot_end));
  // R9
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> done);
  // R3
  wr_slot_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> slot_end);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEEK) |=> ($stable(addr_q) && $stable(din_q) && $stable(op_q)));
endmodule

// File: rtl/dlm_top.sv
module dlm_top #(
  parameter int BYTES_LOG2 = 8,
  parameter int LOOPS_LOG2 = 1,
  parameter int SLOT_CYC = 4,
  localparam int ADDR_W = BYTES_LOG2 + LOOPS_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              done
);
  localparam int NIB_W  = BYTES_LOG2 + 1;
  localparam int NLOOPS = 1 << LOOPS_LOG2;

  logic                  slot_start, slot_end, first_rev;
  logic [NIB_W-1:0]      nib_pos;
  logic [LOOPS_LOG2-1:0] loop_sel;
  logic                  ctrl_we;
  logic [3:0]            ctrl_nib;
  logic [3:0]            rd_nib;
  logic [3:0]            loop_rd [NLOOPS];

  dlm_timer #(.BYTES_LOG2(BYTES_LOG2), .SLOT_CYC(SLOT_CYC)) u_timer (
    .clk(clk), .rst(rst), .slot_start(slot_start), .slot_end(slot_end),
    .nib_pos(nib_pos), .first_rev(first_rev)
  );

  for (genvar i = 0; i < NLOOPS; i++) begin : g_loop
    logic sel_wr;
    logic we;
    logic [3:0] wd;
    assign sel_wr = ctrl_we && (loop_sel == LOOPS_LOG2'(i));
    assign we     = sel_wr || (first_rev && slot_start);
    assign wd     = sel_wr ? ctrl_nib : 4'h0;
    dlm_loop #(.NIB_W(NIB_W)) u_loop (
      .clk(clk), .pos(nib_pos), .we(we), .wdata(wd), .rdata(loop_rd[i])
    );
  end

  assign rd_nib = loop_rd[loop_sel];

  dlm_ctrl #(.BYTES_LOG2(BYTES_LOG2), .LOOPS_LOG2(LOOPS_LOG2)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr), .din(din),
    .slot_end(slot_end), .nib_pos(nib_pos), .first_rev(first_rev),
    .rd_nib(rd_nib), .loop_sel(loop_sel), .wr_en(ctrl_we), .wr_nib(ctrl_nib),
    .dout(dout), .done(done)
  );
endmodule

// File: tb/sim_dlm_top.sv
module sim_dlm_top;
  localparam int BL = 3;
  localparam int LL = 1;
  localparam int S  = 3;
  localparam int NIB = 2 << BL;
  localparam int AW = BL + LL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] op = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic done;
  int tick;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tick <= 0;
    else tick <= tick + 1;
  end

  dlm_top #(.BYTES_LOG2(BL), .LOOPS_LOG2(LL), .SLOT_CYC(S)) u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr), .din(din),
    .dout(dout), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 71) ^ (a << 4));
  endfunction

  task automatic req(input logic [1:0] o, input int a, input logic [7:0] d);
    int s;
    int j;
    int expd;
    int waited;
    @(negedge clk);
    start = 1'b1; op = o; addr = AW'(a); din = d;
    s = tick;
    j = s + 1;
    while (!(((j % S) == S - 1) && (((j / S) % NIB) == 2 * (a % (1 << BL))))) j++;
    expd = j + S + 1;
    @(negedge clk);
    start = 1'b0; op = ~o; addr = ~AW'(a); din = ~d;
    waited = 0;
    if (!done) begin
      @(negedge clk);
      start = 1'b1;
      waited = 1;
    end
    while (!done && waited < 4 * NIB * S) begin
      @(negedge clk);
      start = 1'b0;
      waited++;
    end
    start = 1'b0;
    // R4: done arrives exactly when the addressed byte has passed
    chk(done && tick == expd, "R4 latency", tick, expd);
    @(negedge clk);
    // R5: single-cycle pulse
    chk(!done, "R5 pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(dout == 8'h00, "R1 dout after reset", int'(dout), 0);

    // R1: every location reads zero, first revolution and later
    for (int a = 0; a < (1 << AW); a++) begin
      req(2'b00, a, 8'hA5);
      chk(dout == 8'h00, "R1 fresh read", int'(dout), 0);
    end

    // R3, R2: write opcode 01 stores data
    for (int a = 0; a < (1 << AW); a++) begin
      held = dout;
      req(2'b01, a, pat(a));
      // R9: write leaves dout alone
      chk(dout == held, "R9 dout hold on write", int'(dout), int'(held));
    end

    // R3, R8, R6: read back, loops independent, latched data
    for (int a = (1 << AW) - 1; a >= 0; a--) begin
      req(2'b00, a, 8'h00);
      chk(dout == pat(a), "R3 R8 readback", int'(dout), int'(pat(a)));
    end

    // R7, R2: both no-operation codes
    for (int a = 0; a < (1 << AW); a += 3) begin
      held = dout;
      req((a % 2 == 0) ? 2'b10 : 2'b11, a, 8'h3C);
      chk(dout == held, "R7 R9 nop keeps dout", int'(dout), int'(held));
    end
    for (int a = 0; a < (1 << AW); a += 3) begin
      req(2'b00, a, 8'h00);
      chk(dout == pat(a), "R7 nop keeps store", int'(dout), int'(pat(a)));
    end

    // R3, R8: rewrite one loop only, other loop intact
    req(2'b01, 5, 8'hE1);
    req(2'b00, 5, 8'h00);
    chk(dout == 8'hE1, "R3 rewrite", int'(dout), 8'hE1);
    req(2'b00, 5 + (1 << BL), 8'h00);
    chk(dout == pat(5 + (1 << BL)), "R8 other loop intact", int'(dout), int'(pat(5 + (1 << BL))));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule